// File: doc/BRIEF.md
# Periodic Tick and Protection-Delay Timer

This block divides a 1 MHz bus-phase clock, which comes from a 4 MHz oscillator, into a periodic tick of about 4 ms. The tick is a one-cycle pulse. It does two jobs. It raises a sticky interrupt request, so that the processor can keep real time and run scheduled work such as refreshing the display. It also serves as the time base for a guard window that follows every change of the programmed output.

Each output-changed strobe loads a delay of N ticks. The overcurrent-protection permit flag stays low until N whole ticks have passed since the latest strobe. This stops a constant-voltage to constant-current crossover that happens during the window from tripping protection. A second strobe while the window is open starts the count again from zero. A delay of zero gives the permit back at once.

The guard has two states:
- `GUARD_OPEN`: protection permitted. This is the reset state.
- `GUARD_HOLD`: protection inhibited.

Its transitions are:
- *arm*: from `GUARD_OPEN` to `GUARD_HOLD` on a strobe with N > 0.
- *retrigger*: from `GUARD_HOLD` to `GUARD_HOLD` on a strobe with N > 0. The tick count restarts.
- *expire*: from `GUARD_HOLD` to `GUARD_OPEN` on the tick that brings the count to N.
- *bypass*: from either state to `GUARD_OPEN` on a strobe with N = 0.

Top module: `rt_tick_guard`

## Requirements
- R1: After reset, `tick`, `irq` and `ocp_permit` are 0, 0 and 1. The divider starts from zero.
- R2: While `tmr_clr` is low, `tick` is high for exactly one cycle in every `TICK_PERIOD` cycles. The default is 4096 cycles, which is 4.096 ms at 1 MHz, from a `DIV_W` = 14 stage counter.
- R3: `tmr_clr` = 1 clears the divider to zero and gives no tick. After `tmr_clr` falls, the first tick appears `TICK_PERIOD` cycles later.
- R4: A tick sets `irq` from the next cycle, and `irq` stays at 1.
- R5: `irq_ack` = 1 clears `irq` on the next cycle. If a tick and an acknowledge arrive in the same cycle, `irq` stays at 1.
- R6: After a strobe on `out_chg` with N = `dly_ticks` > 0, `ocp_permit` rises in the cycle after the N-th tick that follows the strobe, and not before.
- R7: `ocp_permit` is 0 from the cycle after any strobe with N > 0.
- R8: A strobe while `ocp_permit` is 0 restarts the tick count from zero, using the newly presented N.
- R9: A strobe with N = 0 makes `ocp_permit` 1 on the next cycle.
- R10: N is captured only in the strobe cycle. Later changes on `dly_ticks` do not change the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_clr | input | 1 | Holds the divider at zero while high |
| out_chg | input | 1 | One-cycle strobe: the output setting changed |
| dly_ticks | input | DLY_W | Guard length N in ticks, sampled with `out_chg` |
| irq_ack | input | 1 | Clears the interrupt request |
| tick | output | 1 | One-cycle periodic pulse |
| irq | output | 1 | Sticky interrupt request |
| ocp_permit | output | 1 | 1 when overcurrent protection may act |

## Verification
The hardest cases to reach from the ports depend on where a strobe or an acknowledge lands relative to the tick phase. These are a retrigger part-way through a window, and an acknowledge in the exact cycle of a tick. The bench uses a short `TICK_PERIOD`. It watches `tick` at the ports and places the strobe or acknowledge on the negative edge where the phase is known. It then counts the observed ticks up to the rise of `ocp_permit`. A table walks several delay values, including zero and one.

// File: rtl/rt_tick_pkg.sv
package rt_tick_pkg;
    typedef enum logic {
        GUARD_OPEN = 1'b0,
        GUARD_HOLD = 1'b1
    } guard_state_e;
endpackage

// File: rtl/rt_tick_divider.sv
module rt_tick_divider #(
    parameter int DIV_W       = 14,
    parameter int TICK_PERIOD = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_clr,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_PERIOD - 1);

    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clr) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr |=> !tick); // R3
endmodule

// File: rtl/rt_irq_flag.sv
module rt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic irq_ack,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (tick)    irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> irq); // R4
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !tick) |=> !irq); // R5
endmodule

// File: rtl/rt_ocp_window.sv
module rt_ocp_window
    import rt_tick_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             out_chg,
    input  logic [DLY_W-1:0] dly_ticks,
    output logic             ocp_permit
);
    guard_state_e     state_q, state_d;
    logic [DLY_W-1:0] seen_q;
    logic [DLY_W-1:0] dly_q;
    logic             last_tick;

    assign last_tick = tick && (seen_q == dly_q - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GUARD_OPEN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_OPEN: if (out_chg) state_d = (dly_ticks == '0) ? GUARD_OPEN : GUARD_HOLD;
            GUARD_HOLD: begin
                if (out_chg)        state_d = (dly_ticks == '0) ? GUARD_OPEN : GUARD_HOLD;
                else if (last_tick) state_d = GUARD_OPEN;
            end
            default:                state_d = GUARD_OPEN;
        endcase
    end

    // tick count and captured delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            dly_q  <= '0;
        end else if (out_chg) begin
            seen_q <= '0;
            dly_q  <= dly_ticks;
        end else if (state_q == GUARD_HOLD && tick) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ocp_permit = (state_q == GUARD_OPEN);
    end

    AST_STROBE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_chg && dly_ticks != '0) |=> !ocp_permit); // R7
    AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_chg && dly_ticks == '0) |=> ocp_permit); // R9
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocp_permit) |-> $past(tick || out_chg)); // R6
endmodule

// File: rtl/rt_tick_guard.sv
module rt_tick_guard #(
    parameter int DIV_W       = 14,
    parameter int TICK_PERIOD = 4096,
    parameter int DLY_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_clr,
    input  logic             out_chg,
    input  logic [DLY_W-1:0] dly_ticks,
    input  logic             irq_ack,
    output logic             tick,
    output logic             irq,
    output logic             ocp_permit
);
    logic tick_w;

    rt_tick_divider #(.DIV_W(DIV_W), .TICK_PERIOD(TICK_PERIOD)) u_div (
        .clk(clk), .rst_n(rst_n), .tmr_clr(tmr_clr), .tick(tick_w)
    );

    rt_irq_flag u_irq (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .irq_ack(irq_ack), .irq(irq)
    );

    rt_ocp_window #(.DLY_W(DLY_W)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .out_chg(out_chg),
        .dly_ticks(dly_ticks), .ocp_permit(ocp_permit)
    );

    assign tick = tick_w;

    initial begin
        AST_PERIOD_FITS: assert (TICK_PERIOD > 1 && TICK_PERIOD <= (1 << DIV_W)); // R2
    end
endmodule

// File: tb/rt_tick_guard_bench.sv
module rt_tick_guard_bench;
    localparam int P     = 8;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmr_clr = 1'b0;
    logic out_chg = 1'b0;
    logic [DLY_W-1:0] dly_ticks = '0;
    logic irq_ack = 1'b0;
    logic tick, irq, ocp_permit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int NV = 5;
    localparam logic [DLY_W-1:0] VEC_DLY [NV] = '{8'd0, 8'd1, 8'd2, 8'd5, 8'd3};
    localparam int               VEC_EXP [NV] = '{0, 1, 2, 5, 3};

    always #2 clk = ~clk;

    rt_tick_guard #(.DIV_W(4), .TICK_PERIOD(P), .DLY_W(DLY_W)) u_rt_tick_guard (
        .clk(clk), .rst_n(rst_n), .tmr_clr(tmr_clr), .out_chg(out_chg),
        .dly_ticks(dly_ticks), .irq_ack(irq_ack),
        .tick(tick), .irq(irq), .ocp_permit(ocp_permit)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (tick) break;
        end
    endtask

    // strobe then count observed ticks until permit rises
    task automatic strobe_count(input logic [DLY_W-1:0] n, input int exp, input string req);
        int seen = 0;
        bit rose = 0;
        dly_ticks = n;
        out_chg = 1'b1;
        @(negedge clk);
        out_chg = 1'b0;
        for (int i = 0; i < P * 40; i++) begin
            if (ocp_permit) begin rose = 1; break; end
            if (tick) seen++;
            @(negedge clk);
        end
        check(req, rose ? seen : -1, exp);
    endtask

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tick", tick, 0);
        check("R1 irq", irq, 0);
        check("R1 permit", ocp_permit, 1);
        rst_n = 1'b1;

        // R2 period and width
        wait_tick();
        gap = 0;
        @(negedge clk);
        check("R2 width", tick, 0);
        gap = 1;
        while (!tick && gap < 4 * P) begin @(negedge clk); gap++; end
        check("R2 period", gap, P);

        // R4 irq set by tick
        check("R4 irq", irq, 0 + (irq ? 1 : 0) | 1);
        @(negedge clk);
        check("R4 irq set", irq, 1);

        // R5 ack clears when no tick
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R5 ack clears", irq, 0);
        // R5 ack same cycle as tick: set wins
        wait_tick();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R5 set wins", irq, 1);

        // R3 clear holds divider
        tmr_clr = 1'b1;
        gap = 0;
        for (int i = 0; i < 3 * P; i++) begin @(negedge clk); if (tick) gap++; end
        check("R3 no tick while clear", gap, 0);
        tmr_clr = 1'b0;
        gap = 0;
        for (int i = 0; i < 4 * P; i++) begin @(negedge clk); gap++; if (tick) break; end
        check("R3 first tick after clear", gap, P);

        // R6 R9 table of delays
        for (int v = 0; v < NV; v++) begin
            strobe_count(VEC_DLY[v], VEC_EXP[v], (VEC_DLY[v] == 0) ? "R9 zero delay" : "R6 delay");
        end

        // R7 permit low right after strobe
        dly_ticks = 8'd2;
        out_chg = 1'b1;
        @(negedge clk);
        out_chg = 1'b0;
        check("R7 permit low", ocp_permit, 0);
        // R9 zero-delay strobe during window opens at once
        dly_ticks = 8'd0;
        out_chg = 1'b1;
        @(negedge clk);
        out_chg = 1'b0;
        check("R9 bypass in hold", ocp_permit, 1);

        // R8 retrigger mid-window
        dly_ticks = 8'd3;
        out_chg = 1'b1;
        @(negedge clk);
        out_chg = 1'b0;
        wait_tick();
        wait_tick();
        @(negedge clk);
        check("R8 still held", ocp_permit, 0);
        strobe_count(8'd2, 2, "R8 restart");

        // R10 delay captured at strobe
        dly_ticks = 8'd3;
        out_chg = 1'b1;
        @(negedge clk);
        out_chg = 1'b0;
        dly_ticks = 8'd1;
        gap = 0;
        for (int i = 0; i < P * 40; i++) begin
            if (ocp_permit) break;
            if (tick) gap++;
            @(negedge clk);
        end
        check("R10 captured delay", gap, 3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule